// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small field-configurable logic array. Eight runtime inputs, each available in true and inverted form, feed a programmable AND plane of 120 product terms. The OR plane is fixed. Each of ten outputs ORs its own group of terms. The group sizes are 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 for outputs 0 to 9. Each OR result enters an output cell. The cell can pass the sum straight through or hold it in a flip-flop, and it can invert what it presents.

The configuration is one long vector. It is shifted in one bit per clock while `cfg_load` is high. A two-state controller (RUN, LOAD) keeps the array quiet while the vector moves. The new pattern takes effect only once loading ends. The cell flip-flops can be cleared at any time through `arst`. They can be set on a clock edge through `preset`, or written directly through the preload port for test. A low `rst_n` is the power-up reset. It clears the configuration, the flip-flops and the controller.

Controller states and transitions: ST_RUN is entered from reset. It moves to ST_LOAD on a clock edge where `cfg_load` is 1. ST_LOAD returns to ST_RUN on the first edge where `cfg_load` is 0.

Top module: `plc_array`

## Requirements
- R1: While `rst_n` is low, the configuration vector, the flip-flops and the controller are cleared. Directly after reset, `dout` is 0 for every `din`.
- R2: The configuration vector (1940 bits) shifts in at every clock edge where `cfg_load` is 1. The bit sent last lands at position 0. Bit 2*o selects the registered path of output o (1 = registered). Bit 2*o+1 inverts output o (1 = inverted). Term k (outputs in ascending order, terms in ascending order within each output) owns bits 20+16k to 20+16k+15. In that field, bit 2i connects input i true and bit 2i+1 connects input i inverted. From the edge that enters ST_LOAD until the edge that leaves it, `dout` is 0, and `preset`, preload and the sums leave the flip-flops unchanged.
- R3: A product term is 1 when it has at least one connected literal and every connected literal is 1. A term with no connected literal is 0. A term that connects both forms of the same input is 0.
- R4: Output o ORs exactly its own group of terms. The groups hold 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 terms for outputs 0 to 9, and the last term of each group counts.
- R5: With its path bit 0, an output follows its sum (after polarity) in the same cycle.
- R6: Every cell flip-flop loads its sum on each clock edge in ST_RUN. With its path bit 1, an output shows that stored value.
- R7: Polarity is applied after the path choice, so an inverted registered output shows the complement of the stored bit.
- R8: `arst` high clears all flip-flops at once, without a clock edge, and holds them clear.
- R9: `preset` high at an edge in ST_RUN sets all flip-flops to 1, unless preload is active.
- R10: `preload_en` high at an edge in ST_RUN writes `preload_data` into the flip-flops, with priority over `preset`.
- R11: With `arst` and `preset` both high, the flip-flops stay clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| arst | input | 1 | Asynchronous clear of the output flip-flops |
| cfg_load | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Configuration serial data |
| preset | input | 1 | Synchronous set of the output flip-flops |
| preload_en | input | 1 | Test preload enable |
| preload_data | input | 10 | Values written by preload |
| din | input | 8 | Runtime logic inputs |
| dout | output | 10 | Output cell values |

## Verification
Four things can meet at the same flip-flops in one cycle: `preset`, preload, the asynchronous clear and the start of a configuration load. The bench drives preset and preload together at one edge and expects the preload data. It raises `arst` in the middle of a cycle and keeps `preset` high across the next edge, and expects the cells to stay clear. It holds `preset` and preload high for the whole of a load, and expects the stored values to come out of the load unchanged.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_LOAD = 1'b1
    } cfg_state_e;

    // Group size of output o: grows by step toward the middle, symmetric.
    function automatic int unsigned pt_count(input int unsigned o,
                                             input int unsigned n_out,
                                             input int unsigned pt_min,
                                             input int unsigned pt_step);
        int unsigned d;
        d = (o < (n_out - 1 - o)) ? o : (n_out - 1 - o);
        return pt_min + pt_step * d;
    endfunction

    // Index of the first term owned by output o.
    function automatic int unsigned pt_base(input int unsigned o,
                                            input int unsigned n_out,
                                            input int unsigned pt_min,
                                            input int unsigned pt_step);
        int unsigned acc;
        acc = 0;
        for (int unsigned k = 0; k < o; k++) begin
            acc += pt_count(k, n_out, pt_min, pt_step);
        end
        return acc;
    endfunction

endpackage

// File: rtl/plc_cfg_ctrl.sv
module plc_cfg_ctrl
    import plc_pkg::*;
#(
    parameter int unsigned CFG_W = 1940
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_din,
    output logic [CFG_W-1:0] cfg_q,
    output logic             run
);

    cfg_state_e state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (cfg_load)  state_nx = ST_LOAD;
            ST_LOAD: if (!cfg_load) state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_RUN:  run = 1'b1;
            ST_LOAD: run = 1'b0;
            default: run = 1'b0;
        endcase
    end

    // Configuration shift chain: newest bit enters at position 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_q <= '0;
        else if (cfg_load) cfg_q <= {cfg_q[CFG_W-2:0], cfg_din};
    end

endmodule

// File: rtl/plc_term.sv
module plc_term #(
    parameter int unsigned LIT_W = 16
) (
    input  logic [LIT_W-1:0] lits,
    input  logic [LIT_W-1:0] mask,
    output logic             hit
);

    // Unconnected literals read as 1; a term with nothing connected is 0.
    // Both forms of one input connected give x & ~x = 0 without extra logic.
    always_comb begin
        hit = (|mask) & (&(lits | ~mask));
    end

endmodule

// File: rtl/plc_macrocell.sv
module plc_macrocell (
    input  logic clk,
    input  logic rst_n,
    input  logic arst,
    input  logic run,
    input  logic preset,
    input  logic preload_en,
    input  logic preload_bit,
    input  logic sum,
    input  logic reg_sel,
    input  logic inv,
    output logic q,
    output logic y
);

    always_ff @(posedge clk or negedge rst_n or posedge arst) begin
        if (!rst_n)          q <= 1'b0;
        else if (arst)       q <= 1'b0;
        else if (run) begin
            if (preload_en)  q <= preload_bit;
            else if (preset) q <= 1'b1;
            else             q <= sum;
        end
    end

    logic path;

    always_comb begin
        path = reg_sel ? q : sum;
        y    = run ? (path ^ inv) : 1'b0;
    end

endmodule

// File: rtl/plc_array.sv
module plc_array
    import plc_pkg::*;
#(
    parameter int unsigned N_IN    = 8,
    parameter int unsigned N_OUT   = 10,
    parameter int unsigned PT_MIN  = 8,
    parameter int unsigned PT_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arst,
    input  logic             cfg_load,
    input  logic             cfg_din,
    input  logic             preset,
    input  logic             preload_en,
    input  logic [N_OUT-1:0] preload_data,
    input  logic [N_IN-1:0]  din,
    output logic [N_OUT-1:0] dout
);

    localparam int unsigned LIT_W    = 2 * N_IN;
    localparam int unsigned MC_W     = 2 * N_OUT;
    localparam int unsigned PT_TOTAL = pt_base(N_OUT, N_OUT, PT_MIN, PT_STEP);
    localparam int unsigned CFG_W    = MC_W + PT_TOTAL * LIT_W;

    logic [CFG_W-1:0] cfg_q;
    logic             run;
    logic [LIT_W-1:0] lits;
    logic [N_OUT-1:0] reg_q;

    plc_cfg_ctrl #(.CFG_W(CFG_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_din  (cfg_din),
        .cfg_q    (cfg_q),
        .run      (run)
    );

    // True / complement literal buffers
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[2*i]   = din[i];
        assign lits[2*i+1] = ~din[i];
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam int unsigned CNT  = pt_count(o, N_OUT, PT_MIN, PT_STEP);
        localparam int unsigned BASE = pt_base(o, N_OUT, PT_MIN, PT_STEP);

        logic [CNT-1:0] hits;
        logic           sum;

        for (genvar t = 0; t < CNT; t++) begin : g_pt
            plc_term #(.LIT_W(LIT_W)) u_term (
                .lits (lits),
                .mask (cfg_q[MC_W + (BASE + t) * LIT_W +: LIT_W]),
                .hit  (hits[t])
            );
        end

        assign sum = |hits;

        plc_macrocell u_mc (
            .clk         (clk),
            .rst_n       (rst_n),
            .arst        (arst),
            .run         (run),
            .preset      (preset),
            .preload_en  (preload_en),
            .preload_bit (preload_data[o]),
            .sum         (sum),
            .reg_sel     (cfg_q[2*o]),
            .inv         (cfg_q[2*o+1]),
            .q           (reg_q[o]),
            .y           (dout[o])
        );
    end

endmodule

// File: rtl/plc_array_chk.sv
module plc_array_chk #(
    parameter int unsigned N_OUT = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arst,
    input logic             cfg_load,
    input logic             preset,
    input logic             preload_en,
    input logic [N_OUT-1:0] preload_data,
    input logic [N_OUT-1:0] dout,
    input logic             run,
    input logic [N_OUT-1:0] reg_q
);

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && $past(cfg_load)) |-> (dout == '0)); // R2

    AST_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || arst)
        !run |=> $stable(reg_q)); // R2

    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n || arst)
        (run && preset && !preload_en) |=> (&reg_q)); // R9

    AST_PRELOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n || arst)
        (run && preload_en) |=> (reg_q == $past(preload_data))); // R10

    always @(posedge clk) begin
        if (rst_n && arst) begin
            AST_ARST_CLEAR: assert (reg_q == '0); // R8
        end
        if (rst_n && arst && preset) begin
            AST_ARST_OVER_PRESET: assert (reg_q == '0); // R11
        end
        if (!rst_n) begin
            AST_RESET_QUIET: assert (dout == '0); // R1
        end
    end

endmodule

bind plc_array plc_array_chk #(.N_OUT(N_OUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arst         (arst),
    .cfg_load     (cfg_load),
    .preset       (preset),
    .preload_en   (preload_en),
    .preload_data (preload_data),
    .dout         (dout),
    .run          (run),
    .reg_q        (reg_q)
);

// File: tb/plc_array_tb.sv
module plc_array_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_IN  = 8;
    localparam int N_OUT = 10;
    localparam int LIT_W = 16;
    localparam int MC_W  = 20;
    localparam int CFG_W = MC_W + 120 * LIT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arst = 1'b0;
    logic             cfg_load = 1'b0;
    logic             cfg_din = 1'b0;
    logic             preset = 1'b0;
    logic             preload_en = 1'b0;
    logic [N_OUT-1:0] preload_data = '0;
    logic [N_IN-1:0]  din = '0;
    logic [N_OUT-1:0] dout;

    int checks = 0;
    int failures = 0;

    logic [CFG_W-1:0] cfgm = '0;
    logic [CFG_W-1:0] build = '0;
    logic [N_OUT-1:0] qm = '0;

    plc_array u_dut (
        .clk(clk), .rst_n(rst_n), .arst(arst), .cfg_load(cfg_load),
        .cfg_din(cfg_din), .preset(preset), .preload_en(preload_en),
        .preload_data(preload_data), .din(din), .dout(dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int cnt_of(int o);
        int d;
        d = (o < N_OUT - 1 - o) ? o : N_OUT - 1 - o;
        return 8 + 2 * d;
    endfunction

    function automatic int base_of(int o);
        int acc = 0;
        for (int k = 0; k < o; k++) acc += cnt_of(k);
        return acc;
    endfunction

    function automatic logic sum_of(int o, logic [N_IN-1:0] d);
        logic [LIT_W-1:0] lv, m;
        logic s = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            lv[2*i] = d[i];
            lv[2*i+1] = ~d[i];
        end
        for (int t = 0; t < cnt_of(o); t++) begin
            m = cfgm[MC_W + (base_of(o) + t) * LIT_W +: LIT_W];
            if (m != '0 && (lv | ~m) == '1) s = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [N_OUT-1:0] out_of(logic [N_IN-1:0] d);
        logic [N_OUT-1:0] r;
        for (int o = 0; o < N_OUT; o++) begin
            r[o] = (cfgm[2*o] ? qm[o] : sum_of(o, d)) ^ cfgm[2*o+1];
        end
        return r;
    endfunction

    function automatic logic [N_OUT-1:0] next_q(logic [N_IN-1:0] d, logic pre,
                                                logic pl, logic [N_OUT-1:0] pd);
        logic [N_OUT-1:0] r;
        if (arst)     r = '0;
        else if (pl)  r = pd;
        else if (pre) r = '1;
        else for (int o = 0; o < N_OUT; o++) r[o] = sum_of(o, d);
        return r;
    endfunction

    task automatic chk(string tag, logic [N_OUT-1:0] act, logic [N_OUT-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: dout=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(string tag, logic [N_IN-1:0] d, logic pre, logic pl,
                        logic [N_OUT-1:0] pd);
        logic [N_OUT-1:0] nq;
        din = d; preset = pre; preload_en = pl; preload_data = pd;
        #1;
        chk(tag, dout, out_of(d));
        nq = next_q(d, pre, pl, pd);
        @(posedge clk);
        qm = nq;
        @(negedge clk);
    endtask

    // Shifts 'build' in, last bit first out is bit 0; preset/preload are
    // held high during the load and must be ignored.
    task automatic load_cfg();
        logic [N_OUT-1:0] nq;
        cfg_load = 1'b1; preset = 1'b0; preload_en = 1'b0;
        for (int i = CFG_W - 1; i >= 0; i--) begin
            cfg_din = build[i];
            if (i == CFG_W - 1) nq = next_q(din, 1'b0, 1'b0, '0);
            @(posedge clk);
            @(negedge clk);
            if (i == CFG_W - 1) begin
                qm = nq;
                preset = 1'b1; preload_en = 1'b1; preload_data = 10'h3C5;
            end
            if (i % 400 == 0) chk("R2 quiet during load", dout, '0);
        end
        cfg_load = 1'b0;
        #1;
        chk("R2 quiet on last load cycle", dout, '0);
        @(posedge clk);
        @(negedge clk);
        preset = 1'b0; preload_en = 1'b0;
        cfgm = build;
    endtask

    function automatic void set_lit(int o, int t, int lit);
        build[MC_W + (base_of(o) + t) * LIT_W + lit] = 1'b1;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset
        din = 8'hA5;
        repeat (3) @(negedge clk);
        chk("R1 dout during reset", dout, '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) step("R1 blank config", 8'($urandom), 1'b0, 1'b0, '0);
        chk("R1 dout zero after reset", dout, '0);

        // Config A: combinational, last term of each group uses din[o%8];
        // term 0 of output 0 connects both forms of din[1].
        build = '0;
        for (int o = 0; o < N_OUT; o++) set_lit(o, cnt_of(o) - 1, 2 * (o % N_IN));
        set_lit(0, 0, 2);
        set_lit(0, 0, 3);
        din = '0;
        load_cfg();
        din = 8'h01; #1;
        chk("R4 last term of groups 0 and 8", dout, 10'h101);
        din = 8'h02; #1;
        chk("R3 conflicting term stays 0, R5 comb follow", dout, 10'h202);
        @(negedge clk);
        step("R3 R4 R5 all ones", 8'hFF, 1'b0, 1'b0, '0);
        for (int k = 0; k < N_IN; k++) step("R4 walking one", 8'(1 << k), 1'b0, 1'b0, '0);
        step("R5 zero", 8'h00, 1'b0, 1'b0, '0);

        // Config B: same terms, all registered, odd outputs inverted.
        for (int o = 0; o < N_OUT; o++) begin
            build[2*o] = 1'b1;
            build[2*o+1] = (o % 2 == 1);
        end
        din = '0;
        load_cfg();
        #1;
        chk("R2 R7 stored zeros held through load, inverted odd", dout, 10'h2AA);
        @(negedge clk);
        step("R6 before edge", 8'hFF, 1'b0, 1'b0, '0);
        #1;
        chk("R6 registered after edge", dout, 10'h155);
        @(negedge clk);
        step("R10 preload", 8'hFF, 1'b0, 1'b1, 10'h00F);
        #1;
        chk("R10 preload value", dout, 10'h2A5);
        @(negedge clk);
        step("R10 preload over preset", 8'hFF, 1'b1, 1'b1, 10'h000);
        #1;
        chk("R10 preload beats preset", dout, 10'h2AA);
        @(negedge clk);
        step("R9 preset", 8'h00, 1'b1, 1'b0, '0);
        #1;
        chk("R9 preset sets all", dout, 10'h155);
        @(negedge clk);
        #2 arst = 1'b1;
        qm = '0;
        #1;
        chk("R8 async clear mid cycle", dout, 10'h2AA);
        @(negedge clk);
        step("R11 arst with preset", 8'hFF, 1'b1, 1'b0, '0);
        #1;
        chk("R11 reset wins over preset", dout, 10'h2AA);
        @(negedge clk);
        arst = 1'b0;
        step("R6 after clear", 8'hFF, 1'b0, 1'b0, '0);

        // Random configurations and stimulus
        for (int c = 0; c < 6; c++) begin
            for (int b = 0; b < MC_W; b++) build[b] = 1'($urandom);
            for (int b = MC_W; b < CFG_W; b++) build[b] = ($urandom % 5 == 0);
            din = 8'($urandom);
            load_cfg();
            for (int s = 0; s < 150; s++) begin
                step("R3 R5 R6 R7 R9 R10 random", 8'($urandom),
                     ($urandom % 10 == 0), ($urandom % 12 == 0), 10'($urandom));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule